// File: doc/BRIEF.md
# Radio Transceiver State Controller

This block sequences the operating states of a low-power packet radio. It decides when the radio sleeps, idles with its synthesizer locked, listens, receives and transmits. Software moves it between states by writing command codes. A single external control pin also drives it, and the meaning of that pin depends on the current state. While the radio listens, a rising edge on the pin keeps the receiver running but stops the master clock that is sent to the host. While the synthesizer is locked, a rising edge on the pin starts a transmission.

When a transmission starts, the block asks the synthesizer to move to the transmit frequency and turns on the power amplifier. It then waits a settling time and emits a strobe marking the first chip of the header. After the header it either finishes at once (when the length field is zero) or waits for the modem to report that the frame is done. In both cases it returns to the locked idle state and raises a one-cycle end-of-frame interrupt. The RF, synthesizer, modem, register access and frame storage are outside the block and are replaced by strobes and a length input.

Top module: `trx_state_ctrl`

## Requirements
- R1: While `rst_n` is low, `state_o` reads INIT (1), `clk_en_o` is 1, and `pa_en_o`, `pll_tx_o`, `tx_start_o` and `frame_end_o` are 0. On the first clock edge after release, the state becomes READY (2).
- R2: `ctl_pin_i` passes through a two-flop synchronizer. A pin change sampled at clock edge k acts on the state at edge k+2.
- R3: LISTEN_QUIET (5) is entered only from LISTEN (4), on a synchronized rising edge of the pin. A rising edge during RX_BUSY (6) has no effect after reception ends: the state returns to LISTEN and stays there until the pin rises again.
- R4: With clock-rate codes 0 to 5, `clk_en_o` stays 1 for exactly CLK_OFF_DLY (35) cycles after the state becomes LISTEN_QUIET, then drops to 0.
- R5: With clock-rate codes 6 or 7 (the two slowest rates, written with `cfg_we`/`cfg_rate`), `clk_en_o` is 0 in the first cycle in which the state reads LISTEN_QUIET.
- R6: In LISTEN_QUIET, `rx_detect_i` moves the state to RX_BUSY at the next edge and restores `clk_en_o` to 1 at that edge. This holds even when the pin goes low in the same cycle. `rx_end_i` in RX_BUSY returns the state to LISTEN.
- R7: In LISTEN_QUIET, a synchronized low pin moves the state to LISTEN with `clk_en_o` equal to 1.
- R8: TX_BUSY (3) is entered only from READY. Entry happens on a synchronized pin rising edge or on command code 1 (send). Command 1 has no effect in LISTEN. Command 2 moves LISTEN to READY, and command 3 moves READY to LISTEN.
- R9: Throughout TX_BUSY, `pa_en_o` and `pll_tx_o` are 1. `tx_start_o` is a single-cycle pulse that starts exactly 16*CLK_MHZ cycles after the edge that entered TX_BUSY.
- R10: If `frame_len_i` is zero when the header ends (HDR_US*CLK_MHZ cycles after the start pulse), the state returns to READY one edge later. `frame_end_o` is then 1 for one cycle, and `pa_en_o` and `pll_tx_o` are 0.
- R11: With a nonzero length, `tx_done_i` before the header ends is ignored. `tx_done_i` afterwards returns the state to READY at the next edge with a one-cycle `frame_end_o`.
- R12: Command 4 (reinitialize) passes through INIT (1) for one cycle and then goes to READY. It keeps the stored clock-rate code.
- R13: Command 4 issued in LISTEN_QUIET while the synchronized pin is high goes straight to SLEEP (0) with `clk_en_o` equal to 0. A low pin in SLEEP leads through INIT to READY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_pin_i | input | 1 | Asynchronous sleep/transmit control pin |
| cmd_valid_i | input | 1 | Command write strobe |
| cmd_code_i | input | 3 | Command: 1 send, 2 go ready, 3 go listen, 4 reinitialize |
| cfg_we_i | input | 1 | Clock-rate code write strobe |
| cfg_rate_i | input | 3 | Clock-rate code; 6 and 7 are the slow rates |
| rx_detect_i | input | 1 | Incoming frame detected strobe |
| rx_end_i | input | 1 | Reception complete strobe |
| frame_len_i | input | 7 | Frame length field of the frame being sent |
| tx_done_i | input | 1 | Frame body transmission complete strobe |
| state_o | output | 4 | Current state code |
| clk_en_o | output | 1 | Enable for the master clock sent to the host |
| pa_en_o | output | 1 | Power amplifier enable |
| pll_tx_o | output | 1 | Request to move the synthesizer to the transmit frequency |
| tx_start_o | output | 1 | First header chip strobe |
| frame_end_o | output | 1 | End-of-frame interrupt pulse |

## Verification
In LISTEN_QUIET, a frame detection and the pin going low both ask to leave the state, and they can arrive in the same cycle. The bench lowers the pin and then raises `rx_detect_i` in the cycle when the synchronized low level first reaches the state logic, so both act at the same edge. The run passes only if the state lands in RX_BUSY with the clock enabled, and a later `rx_end_i` returns it to LISTEN.

// File: rtl/trx_pkg.sv
package trx_pkg;

   typedef enum logic [3:0] {
      ST_SLEEP  = 4'd0,
      ST_INIT   = 4'd1,
      ST_READY  = 4'd2,
      ST_TX     = 4'd3,
      ST_LISTEN = 4'd4,
      ST_QUIET  = 4'd5,
      ST_RX     = 4'd6
   } trx_state_e;

   typedef enum logic [2:0] {
      CMD_NONE   = 3'd0,
      CMD_SEND   = 3'd1,
      CMD_READY  = 3'd2,
      CMD_LISTEN = 3'd3,
      CMD_INIT   = 3'd4
   } trx_cmd_e;

   typedef enum logic [1:0] {
      PH_SETTLE = 2'd0,
      PH_HDR    = 2'd1,
      PH_BODY   = 2'd2
   } tx_phase_e;

endpackage

// File: rtl/trx_pin_sync.sv
module trx_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o,
   output logic rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("trx_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/trx_clk_gate.sv
module trx_clk_gate #(
   parameter int OFF_DLY = 35
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_i,
   input  logic quiet_nxt_i,
   input  logic sleep_nxt_i,
   input  logic quiet_cur_i,
   input  logic sleep_cur_i,
   output logic clk_en_o
);

   if (OFF_DLY < 1) begin : g_bad_dly
      $error("trx_clk_gate: OFF_DLY must be at least 1");
   end

   logic clk_en_q;
   logic enter_w;
   logic stay_w;

   assign enter_w = quiet_nxt_i & ~quiet_cur_i;
   assign stay_w  = quiet_nxt_i & quiet_cur_i;

   if (OFF_DLY == 1) begin : g_no_counter
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           clk_en_q <= 1'b1;
         else if (sleep_nxt_i) clk_en_q <= 1'b0;
         else if (enter_w)     clk_en_q <= ~slow_i;
         else if (stay_w)      clk_en_q <= 1'b0;
         else                  clk_en_q <= 1'b1;
      end
   end else begin : g_counter
      localparam int CW = $clog2(OFF_DLY);
      logic [CW-1:0] wait_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            clk_en_q <= 1'b1;
            wait_q   <= '0;
         end else if (sleep_nxt_i) begin
            clk_en_q <= 1'b0;
            wait_q   <= '0;
         end else if (enter_w) begin
            clk_en_q <= ~slow_i;
            wait_q   <= slow_i ? '0 : CW'(OFF_DLY - 1);
         end else if (stay_w) begin
            clk_en_q <= clk_en_q & (wait_q != '0);
            if (wait_q != '0) wait_q <= wait_q - 1'b1;
         end else begin
            clk_en_q <= 1'b1;
            wait_q   <= '0;
         end
      end
   end

   assign clk_en_o = clk_en_q;

   // R4: the host clock is only ever stopped while quiet-listening or asleep
   assert_gate_scope_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en_q |-> (quiet_cur_i || sleep_cur_i));

endmodule

// File: rtl/trx_tx_seq.sv
module trx_tx_seq
   import trx_pkg::*;
#(
   parameter int SETTLE_CYC = 256,
   parameter int HDR_CYC    = 2560,
   parameter int LEN_W      = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             active_i,
   input  logic [LEN_W-1:0] frame_len_i,
   input  logic             tx_done_i,
   output logic             tx_start_o,
   output logic             done_o
);

   if (SETTLE_CYC < 1 || HDR_CYC < 1) begin : g_bad_times
      $error("trx_tx_seq: SETTLE_CYC and HDR_CYC must be at least 1");
   end

   localparam int MAXC = (SETTLE_CYC > HDR_CYC) ? SETTLE_CYC : HDR_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   tx_phase_e     phase_q;
   logic [CW-1:0] cnt_q;
   logic          cnt_zero;

   assign cnt_zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_SETTLE;
         cnt_q   <= '0;
      end else if (load_i) begin
         phase_q <= PH_SETTLE;
         cnt_q   <= CW'(SETTLE_CYC);
      end else if (active_i) begin
         case (phase_q)
            PH_SETTLE: begin
               if (cnt_zero) begin
                  phase_q <= PH_HDR;
                  cnt_q   <= CW'(HDR_CYC - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_HDR: begin
               if (cnt_zero) phase_q <= PH_BODY;
               else          cnt_q   <= cnt_q - 1'b1;
            end
            default: phase_q <= PH_BODY;
         endcase
      end
   end

   assign tx_start_o = active_i && (phase_q == PH_SETTLE) && cnt_zero;
   assign done_o     = active_i &&
                       (((phase_q == PH_HDR) && cnt_zero && (frame_len_i == '0)) ||
                        ((phase_q == PH_BODY) && tx_done_i));

   // R9: the first-chip strobe never lasts longer than one cycle
   assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start_o |=> !tx_start_o);

endmodule

// File: rtl/trx_state_ctrl.sv
module trx_state_ctrl
   import trx_pkg::*;
#(
   parameter int CLK_MHZ     = 16,
   parameter int SETTLE_US   = 16,
   parameter int HDR_US      = 160,
   parameter int CLK_OFF_DLY = 35,
   parameter int LEN_W       = 7,
   parameter int RATE_W      = 3,
   parameter int RATE_RST    = 1,
   parameter int SLOW_RATE_A = 6,
   parameter int SLOW_RATE_B = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_pin_i,
   input  logic              cmd_valid_i,
   input  logic [2:0]        cmd_code_i,
   input  logic              cfg_we_i,
   input  logic [RATE_W-1:0] cfg_rate_i,
   input  logic              rx_detect_i,
   input  logic              rx_end_i,
   input  logic [LEN_W-1:0]  frame_len_i,
   input  logic              tx_done_i,
   output logic [3:0]        state_o,
   output logic              clk_en_o,
   output logic              pa_en_o,
   output logic              pll_tx_o,
   output logic              tx_start_o,
   output logic              frame_end_o
);

   localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
   localparam int HDR_CYC    = CLK_MHZ * HDR_US;

   if (CLK_MHZ < 1) begin : g_bad_clk
      $error("trx_state_ctrl: CLK_MHZ must be at least 1");
   end
   if (SLOW_RATE_A >= (1 << RATE_W) || SLOW_RATE_B >= (1 << RATE_W)) begin : g_bad_rate
      $error("trx_state_ctrl: slow rate codes do not fit RATE_W");
   end

   trx_state_e        state_q, state_nxt;
   logic [RATE_W-1:0] rate_q;
   logic              frame_end_q;
   logic              pin_lvl, pin_rise;
   logic              seq_done, seq_load;
   logic              init_cmd, slow_rate;

   trx_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (ctl_pin_i),
      .level_o (pin_lvl),
      .rise_o  (pin_rise)
   );

   // clock-rate code survives reinitialization, only the async reset clears it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rate_q <= RATE_W'(RATE_RST);
      else if (cfg_we_i) rate_q <= cfg_rate_i;
   end

   assign slow_rate = (rate_q == RATE_W'(SLOW_RATE_A)) || (rate_q == RATE_W'(SLOW_RATE_B));
   assign init_cmd  = cmd_valid_i && (cmd_code_i == CMD_INIT);

   always_comb begin
      state_nxt = state_q;
      if (init_cmd) begin
         state_nxt = (state_q == ST_QUIET && pin_lvl) ? ST_SLEEP : ST_INIT;
      end else begin
         case (state_q)
            ST_SLEEP:  if (!pin_lvl) state_nxt = ST_INIT;
            ST_INIT:   state_nxt = ST_READY;
            ST_READY: begin
               if (pin_rise || (cmd_valid_i && cmd_code_i == CMD_SEND))
                  state_nxt = ST_TX;
               else if (cmd_valid_i && cmd_code_i == CMD_LISTEN)
                  state_nxt = ST_LISTEN;
            end
            ST_TX:     if (seq_done) state_nxt = ST_READY;
            ST_LISTEN: begin
               if (rx_detect_i)
                  state_nxt = ST_RX;
               else if (pin_rise)
                  state_nxt = ST_QUIET;
               else if (cmd_valid_i && cmd_code_i == CMD_READY)
                  state_nxt = ST_READY;
            end
            ST_QUIET: begin
               if (rx_detect_i)   state_nxt = ST_RX;
               else if (!pin_lvl) state_nxt = ST_LISTEN;
            end
            ST_RX:     if (rx_end_i) state_nxt = ST_LISTEN;
            default:   state_nxt = ST_INIT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_INIT;
         frame_end_q <= 1'b0;
      end else begin
         state_q     <= state_nxt;
         frame_end_q <= (state_q == ST_TX) && (state_nxt == ST_READY);
      end
   end

   assign seq_load = (state_nxt == ST_TX) && (state_q != ST_TX);

   trx_tx_seq #(
      .SETTLE_CYC (SETTLE_CYC),
      .HDR_CYC    (HDR_CYC),
      .LEN_W      (LEN_W)
   ) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (seq_load),
      .active_i    (state_q == ST_TX),
      .frame_len_i (frame_len_i),
      .tx_done_i   (tx_done_i),
      .tx_start_o  (tx_start_o),
      .done_o      (seq_done)
   );

   trx_clk_gate #(.OFF_DLY(CLK_OFF_DLY)) i_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .slow_i      (slow_rate),
      .quiet_nxt_i (state_nxt == ST_QUIET),
      .sleep_nxt_i (state_nxt == ST_SLEEP),
      .quiet_cur_i (state_q == ST_QUIET),
      .sleep_cur_i (state_q == ST_SLEEP),
      .clk_en_o    (clk_en_o)
   );

   assign state_o     = state_q;
   assign pa_en_o     = (state_q == ST_TX);
   assign pll_tx_o    = (state_q == ST_TX);
   assign frame_end_o = frame_end_q;

   // R3: quiet listening is reached only out of plain listening
   assert_quiet_from_listen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_QUIET) |=> (state_q != ST_QUIET) || ($past(state_q) == ST_LISTEN));

   // R8: transmission is only ever entered from the locked idle state
   assert_tx_from_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_READY && state_q != ST_TX) |=> (state_q != ST_TX));

   // R6: a detected frame wins over every other exit from quiet listening
   assert_quiet_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_QUIET && rx_detect_i && !init_cmd) |=> (state_q == ST_RX) && clk_en_o);

   // R10: the end-of-frame pulse appears only with the amplifier off in ready
   assert_end_in_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end_o |-> (state_q == ST_READY) && !pa_en_o);

endmodule

// File: tb/test_trx_state_ctrl.sv
`timescale 1ns/1ps
module test_trx_state_ctrl;

   localparam int S_CYC = 16 * 16;
   localparam int H_CYC = 160 * 16;
   localparam int NV    = 14;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin = 1'b0;
   logic       cmd_v = 1'b0;
   logic [2:0] cmd = 3'd0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_rate = 3'd0;
   logic       rxd = 1'b0, rxe = 1'b0, txd = 1'b0;
   logic [6:0] flen = 7'd0;
   logic [3:0] st;
   logic       clk_en, pa, pll, txs, irq;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   trx_state_ctrl i_trx_state_ctrl (
      .clk(clk), .rst_n(rst_n), .ctl_pin_i(pin),
      .cmd_valid_i(cmd_v), .cmd_code_i(cmd),
      .cfg_we_i(cfg_we), .cfg_rate_i(cfg_rate),
      .rx_detect_i(rxd), .rx_end_i(rxe),
      .frame_len_i(flen), .tx_done_i(txd),
      .state_o(st), .clk_en_o(clk_en), .pa_en_o(pa), .pll_tx_o(pll),
      .tx_start_o(txs), .frame_end_o(irq)
   );

   // {cmd, pin, rx_detect, rx_end, expected state, expected clk_en}
   localparam logic [10:0] VECS [0:NV-1] = '{
      {3'd3, 1'b0, 1'b0, 1'b0, 4'd4, 1'b1},  // R8 go listen
      {3'd0, 1'b0, 1'b1, 1'b0, 4'd6, 1'b1},  // R6 detect in listen
      {3'd0, 1'b0, 1'b0, 1'b1, 4'd4, 1'b1},  // R6 end of reception
      {3'd0, 1'b1, 1'b0, 1'b0, 4'd5, 1'b1},  // R2 R3 pin rise
      {3'd0, 1'b1, 1'b1, 1'b0, 4'd6, 1'b1},  // R6 detect in quiet
      {3'd0, 1'b1, 1'b0, 1'b1, 4'd4, 1'b1},  // R6 back to listen
      {3'd0, 1'b1, 1'b0, 1'b0, 4'd4, 1'b1},  // R3 no new edge
      {3'd0, 1'b0, 1'b0, 1'b0, 4'd4, 1'b1},  // R3 pin low in listen
      {3'd0, 1'b1, 1'b0, 1'b0, 4'd5, 1'b1},  // R3 fresh edge
      {3'd0, 1'b0, 1'b0, 1'b0, 4'd4, 1'b1},  // R7 pin low in quiet
      {3'd1, 1'b0, 1'b0, 1'b0, 4'd4, 1'b1},  // R8 send ignored in listen
      {3'd2, 1'b0, 1'b0, 1'b0, 4'd2, 1'b1},  // R8 go ready
      {3'd0, 1'b0, 1'b1, 1'b0, 4'd2, 1'b1},  // R8 detect ignored in ready
      {3'd3, 1'b0, 1'b0, 1'b0, 4'd4, 1'b1}   // R8 go listen again
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_cmd(input logic [2:0] c);
      cmd_v = 1'b1; cmd = c;
      step(1);
      cmd_v = 1'b0; cmd = 3'd0;
   endtask

   initial begin
      #(4 * 190000);
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      step(3);
      chk("R1 state in reset", st, 1);
      chk("R1 clk_en in reset", clk_en, 1);
      chk("R1 pa in reset", pa, 0);
      chk("R1 pll in reset", pll, 0);
      chk("R1 start in reset", txs, 0);
      chk("R1 irq in reset", irq, 0);
      rst_n = 1'b1;
      step(1);
      chk("R1 ready after reset", st, 2);

      for (int i = 0; i < NV; i++) begin
         logic [10:0] v;
         v = VECS[i];
         cmd_v = (v[10:8] != 3'd0); cmd = v[10:8];
         pin = v[7]; rxd = v[6]; rxe = v[5];
         step(1);
         cmd_v = 1'b0; cmd = 3'd0; rxd = 1'b0; rxe = 1'b0;
         step(2);
         chk($sformatf("R8 table state %0d", i), st, int'(v[4:1]));
         chk($sformatf("R4 table clk_en %0d", i), clk_en, int'(v[0]));
      end

      // R4 exact off delay at a fast rate, R7 restore
      pin = 1'b1; step(3);
      chk("R4 quiet entered", st, 5);
      chk("R4 clk still on at entry", clk_en, 1);
      step(34);
      chk("R4 clk on at delay-1", clk_en, 1);
      step(1);
      chk("R4 clk off at delay", clk_en, 0);
      pin = 1'b0; step(3);
      chk("R7 listen after pin low", st, 4);
      chk("R7 clk restored", clk_en, 1);

      // R5 slow rate, R13 sleep, R12 rate kept
      cfg_we = 1'b1; cfg_rate = 3'd6; step(1); cfg_we = 1'b0;
      pin = 1'b1; step(3);
      chk("R5 quiet at slow rate", st, 5);
      chk("R5 clk off immediately", clk_en, 0);
      do_cmd(3'd4);
      chk("R13 sleep from quiet", st, 0);
      chk("R13 clk off in sleep", clk_en, 0);
      step(2);
      chk("R13 stays asleep", st, 0);
      pin = 1'b0; step(4);
      chk("R13 wake to ready", st, 2);
      do_cmd(3'd3);
      pin = 1'b1; step(3);
      chk("R12 rate kept after wake", clk_en, 0);
      pin = 1'b0; step(3);
      do_cmd(3'd2);
      do_cmd(3'd4);
      chk("R12 init state", st, 1);
      step(1);
      chk("R12 ready after init", st, 2);
      do_cmd(3'd3);
      pin = 1'b1; step(3);
      chk("R12 rate kept after init", clk_en, 0);
      pin = 1'b0; step(3);
      cfg_we = 1'b1; cfg_rate = 3'd0; step(1); cfg_we = 1'b0;

      // R6 detect and pin low at the same edge
      pin = 1'b1; step(3);
      chk("R6 quiet before race", st, 5);
      pin = 1'b0; step(2);
      rxd = 1'b1; step(1); rxd = 1'b0;
      chk("R6 detect wins", st, 6);
      chk("R6 clk on", clk_en, 1);
      rxe = 1'b1; step(1); rxe = 1'b0;
      chk("R6 listen after race", st, 4);

      // R9 R10 pin-started transmission with zero length
      do_cmd(3'd2);
      flen = 7'd0;
      pin = 1'b1; step(3);
      chk("R8 tx from pin", st, 3);
      chk("R9 pa on", pa, 1);
      chk("R9 pll on", pll, 1);
      chk("R9 no early start", txs, 0);
      step(S_CYC - 1);
      chk("R9 start not yet", txs, 0);
      step(1);
      chk("R9 start pulse", txs, 1);
      step(1);
      chk("R9 start one cycle", txs, 0);
      step(H_CYC - 1);
      chk("R10 still sending header", st, 3);
      step(1);
      chk("R10 abort to ready", st, 2);
      chk("R10 irq", irq, 1);
      chk("R10 pa off", pa, 0);
      chk("R10 pll off", pll, 0);
      step(1);
      chk("R10 irq one cycle", irq, 0);
      pin = 1'b0; step(3);
      chk("R10 pin low keeps ready", st, 2);

      // R11 command-started transmission with a body
      flen = 7'd5;
      do_cmd(3'd1);
      chk("R8 tx from command", st, 3);
      txd = 1'b1; step(1); txd = 1'b0;
      step(S_CYC + H_CYC);
      chk("R11 early done ignored", st, 3);
      step(4);
      chk("R11 waiting for body end", st, 3);
      txd = 1'b1; step(1); txd = 1'b0;
      chk("R11 ready after done", st, 2);
      chk("R11 irq", irq, 1);
      chk("R11 pa off", pa, 0);
      step(1);
      chk("R11 irq one cycle", irq, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule